// File: doc/BRIEF.md
# SPI Register-Access Transaction Master

This block runs one complete SPI transaction against a register file that is addressed through a header of one to three octets. The user side supplies a register identifier, a sub-index, a payload byte count and a direction flag, then pulses `start`. The block checks the arguments and builds the header. It frames the transfer with chip select and shifts the header out in SPI mode 0, most significant bit first. It then moves the payload bytes and pulses `done`. A rejected request pulses `err` instead and causes no bus activity.

The header length follows the sub-index. A zero sub-index needs only the command octet. A sub-index from 1 to 127 adds one octet. A larger sub-index is split across two octets: the first holds the low seven bits with an extension flag in bit 7, and the second holds the index shifted right by seven. Write payload comes in over a valid/ready byte port. Read payload leaves on a one-cycle valid strobe. The SCLK half-period is set at run time in system-clock cycles. A slow setting serves the accesses that must stay below 3 MHz, and a fast setting serves the ordinary ones.

Top module: `spi_reg_master`

## Requirements
- R1: The first header octet is {direction (1 = write, 0 = read) in bit 7, sub-index-present in bit 6, register identifier in bits 5..0}. A zero sub-index gives a one-octet header with bit 6 clear.
- R2: A sub-index of 1 to 127 gives a two-octet header. The second octet has bit 7 clear and the index in bits 6..0.
- R3: A sub-index above 127 gives a three-octet header. The second octet is 0x80 | index[6:0] and the third is index[14:7]. A read of register 0x2E at 0x0806 sends 0x6E, 0x86, 0x10.
- R4: If the identifier exceeds 0x3F, or the sub-index exceeds 0x7FFF, or sub-index plus byte count exceeds 0x7FFF, then `err` is high for exactly the one cycle after the `start` edge and `cs_n` never falls. A sum of exactly 0x7FFF is accepted.
- R5: SCLK idles low. MOSI changes only while SCLK is low and is sent MSB first. MISO is sampled on the rising edge. Each SCLK high phase lasts `div_half`+1 clock cycles.
- R6: `cs_n` falls at least `div_half`+1 cycles before the first rising SCLK edge. It stays low over header and payload and rises at least `div_half`+1 cycles after the last falling edge. `done` pulses in the cycle `cs_n` rises, and `busy` stays high for IDLE_GAP cycles counted from that cycle.
- R7: On a write, each payload byte is taken from `wdata` in a cycle where `wready` and `wvalid` are both high. The bytes go out in order straight after the header.
- R8: On a read, MISO bits clocked during the header are dropped. Each of the `byte_cnt` payload bytes sends 0x00 on MOSI and is delivered on `rdata` with a one-cycle `rvalid`.
- R9: A byte count of zero sends only the header and then completes with `done`.
- R10: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_half | input | DIV_W | SCLK half-period minus one, in clock cycles |
| start | input | 1 | Begin a transaction (sampled while idle) |
| wr_en | input | 1 | 1 = write, 0 = read |
| reg_id | input | 8 | Register identifier (legal range 0..0x3F) |
| sub_idx | input | 16 | Sub-index (legal range 0..0x7FFF) |
| byte_cnt | input | 16 | Payload byte count |
| wdata | input | 8 | Write payload byte |
| wvalid | input | 1 | Write byte offered |
| wready | output | 1 | Write byte accepted this cycle if wvalid |
| rdata | output | 8 | Read payload byte |
| rvalid | output | 1 | One-cycle strobe for rdata |
| busy | output | 1 | Transaction or idle gap in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | One-cycle rejection strobe |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | 1 | SPI chip select, active low |

## Verification
Three results have a fixed latency from `start`. A rejection shows on `err` at the first sample after the clock edge that takes `start`. The SCLK high phase lasts exactly `div_half`+1 cycles. After `done`, `busy` stays high for IDLE_GAP cycles. The bench samples every output on the falling clock edge and counts those cycles exactly. The chip-select lead and tail depend on internal hand-offs, so the bench checks them against their lower bounds. A slave model in the bench captures MOSI on each SCLK rise and shifts MISO on each SCLK fall. Header and payload are compared byte by byte against values the bench computes from the requirements.

// File: rtl/spi_reg_pkg.sv
// Shared types for the SPI register-access master.
// Assumes nothing beyond IEEE 1800-2017 packages.
package spi_reg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HDR,
        ST_PWAIT,
        ST_PAY,
        ST_TAIL,
        ST_GAP
    } xfer_st_t;

    localparam int unsigned IDX_LIMIT = 32'h7FFF;
    localparam int unsigned ID_LIMIT  = 32'h3F;
endpackage

// File: rtl/spi_hdr_builder.sv
// Combinational header composer and argument checker.
// Produces up to three header octets and their count, and flags illegal
// requests. Assumes inputs are stable while the caller samples them.
module spi_hdr_builder (
    input  logic       wr,
    input  logic [7:0] reg_id,
    input  logic [15:0] sub_idx,
    input  logic [15:0] byte_cnt,
    output logic [7:0] oct0,
    output logic [7:0] oct1,
    output logic [7:0] oct2,
    output logic [1:0] n_oct,
    output logic       bad
);
    import spi_reg_pkg::*;

    logic        has_sub;
    logic        ext;
    logic [16:0] span_end;

    // Compose the header octets and their count from the index range.
    always_comb begin
        has_sub  = (sub_idx != 16'd0);
        ext      = (sub_idx > 16'd127);
        oct0     = {wr, has_sub, reg_id[5:0]};
        oct1     = {ext, sub_idx[6:0]};
        oct2     = sub_idx[14:7];
        n_oct    = !has_sub ? 2'd1 : (ext ? 2'd3 : 2'd2);
        span_end = {1'b0, sub_idx} + {1'b0, byte_cnt};
    end

    // Reject identifiers, indices or spans outside the addressable area.
    always_comb begin
        bad = (32'(reg_id) > ID_LIMIT) || (32'(sub_idx) > IDX_LIMIT)
           || (32'(span_end) > IDX_LIMIT);
    end
endmodule

// File: rtl/spi_byte_shifter.sv
// One-byte SPI mode 0 shift engine, MSB first.
// Each SCLK phase lasts half+1 clocks; MISO is sampled as SCLK rises.
// Assumes go is only pulsed while the engine is inactive.
module spi_byte_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half,
    input  logic             go,
    input  logic [7:0]       tx,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic [7:0]       rx,
    output logic             fin
);
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       sh;
    logic             act;

    // Step the SCLK phases and shift data for one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            rx   <= '0;
            act  <= 1'b0;
            sclk <= 1'b0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go && !act) begin
                act  <= 1'b1;
                sh   <= tx;
                cnt  <= '0;
                bitn <= '0;
                sclk <= 1'b0;
            end else if (act) begin
                if (cnt == half) begin
                    cnt <= '0;
                    if (!sclk) begin
                        sclk <= 1'b1;
                        rx   <= {rx[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitn == 3'd7) begin
                            act <= 1'b0;
                            fin <= 1'b1;
                        end else begin
                            bitn <= bitn + 3'd1;
                            sh   <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // The current bit is always the top of the shift register.
    assign mosi = sh[7];
endmodule

// File: rtl/spi_reg_master.sv
// SPI register-access transaction master (top).
// Sequences chip select, header octets and payload bytes through the
// byte shifter. Assumes IDLE_GAP >= 1 and DIV_W <= counter width.
module spi_reg_master #(
    parameter int DIV_W    = 8,
    parameter int IDLE_GAP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_half,
    input  logic             start,
    input  logic             wr_en,
    input  logic [7:0]       reg_id,
    input  logic [15:0]      sub_idx,
    input  logic [15:0]      byte_cnt,
    input  logic [7:0]       wdata,
    input  logic             wvalid,
    output logic             wready,
    output logic [7:0]       rdata,
    output logic             rvalid,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);
    import spi_reg_pkg::*;

    localparam int GAP_W = $clog2(IDLE_GAP + 1);
    localparam int CW    = (DIV_W > GAP_W) ? DIV_W : GAP_W;

    xfer_st_t        st;
    logic [CW-1:0]   cnt;
    logic [7:0]      hb0, hb1, hb2;
    logic [1:0]      hn, hpos;
    logic [15:0]     remain;
    logic            is_wr;
    logic            go;
    logic [7:0]      go_byte;
    logic [7:0]      c0, c1, c2;
    logic [1:0]      cn;
    logic            c_bad;
    logic [7:0]      sh_rx;
    logic            sh_fin;

    spi_hdr_builder u_hdr (
        .wr(wr_en), .reg_id(reg_id), .sub_idx(sub_idx), .byte_cnt(byte_cnt),
        .oct0(c0), .oct1(c1), .oct2(c2), .n_oct(cn), .bad(c_bad)
    );

    spi_byte_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .half(div_half), .go(go), .tx(go_byte),
        .miso(miso), .sclk(sclk), .mosi(mosi), .rx(sh_rx), .fin(sh_fin)
    );

    // Transaction sequencer: framing, header loop, payload loop, idle gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            hb0     <= '0;
            hb1     <= '0;
            hb2     <= '0;
            hn      <= '0;
            hpos    <= '0;
            remain  <= '0;
            is_wr   <= 1'b0;
            go      <= 1'b0;
            go_byte <= '0;
            rdata   <= '0;
            rvalid  <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
            cs_n    <= 1'b1;
        end else begin
            go     <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
            rvalid <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    if (c_bad) begin
                        err <= 1'b1;
                    end else begin
                        hb0    <= c0;
                        hb1    <= c1;
                        hb2    <= c2;
                        hn     <= cn;
                        hpos   <= '0;
                        remain <= byte_cnt;
                        is_wr  <= wr_en;
                        cs_n   <= 1'b0;
                        cnt    <= '0;
                        st     <= ST_LEAD;
                    end
                end
                ST_LEAD: if (cnt == CW'(div_half)) begin
                    go      <= 1'b1;
                    go_byte <= hb0;
                    hpos    <= 2'd1;
                    st      <= ST_HDR;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                ST_HDR: if (sh_fin) begin
                    if (hpos < hn) begin
                        go      <= 1'b1;
                        go_byte <= (hpos == 2'd1) ? hb1 : hb2;
                        hpos    <= hpos + 2'd1;
                    end else if (remain == 16'd0) begin
                        cnt <= '0;
                        st  <= ST_TAIL;
                    end else if (is_wr) begin
                        st <= ST_PWAIT;
                    end else begin
                        go      <= 1'b1;
                        go_byte <= 8'h00;
                        st      <= ST_PAY;
                    end
                end
                ST_PWAIT: if (wvalid) begin
                    go      <= 1'b1;
                    go_byte <= wdata;
                    st      <= ST_PAY;
                end
                ST_PAY: if (sh_fin) begin
                    if (!is_wr) begin
                        rdata  <= sh_rx;
                        rvalid <= 1'b1;
                    end
                    remain <= remain - 16'd1;
                    if (remain == 16'd1) begin
                        cnt <= '0;
                        st  <= ST_TAIL;
                    end else if (is_wr) begin
                        st <= ST_PWAIT;
                    end else begin
                        go      <= 1'b1;
                        go_byte <= 8'h00;
                    end
                end
                ST_TAIL: if (cnt == CW'(div_half)) begin
                    cs_n <= 1'b1;
                    done <= 1'b1;
                    cnt  <= '0;
                    st   <= ST_GAP;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                ST_GAP: if (cnt == CW'(IDLE_GAP - 1)) begin
                    st <= ST_IDLE;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Handshake and activity flags decoded from the sequencer state.
    assign wready = (st == ST_PWAIT);
    assign busy   = (st != ST_IDLE);
endmodule

// File: rtl/spi_reg_master_chk.sv
// Protocol checker for spi_reg_master, attached with bind below.
// Assumes the synchronous active-low reset of the top module.
module spi_reg_master_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic wready,
    input logic rvalid,
    input logic done,
    input logic err,
    input logic sclk,
    input logic mosi,
    input logic cs_n
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R5
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R5
    AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> cs_n); // R4
    AST_ERR_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(start)); // R4
    AST_DONE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(cs_n)); // R6
    AST_RELEASE_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done); // R6
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R6
    AST_WREADY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wready |-> !cs_n); // R7
    AST_RVALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !cs_n); // R8
endmodule

bind spi_reg_master spi_reg_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .wready(wready),
    .rvalid(rvalid), .done(done), .err(err), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n)
);

// File: tb/spi_reg_master_bench.sv
// Directed bench for spi_reg_master with an SPI slave model.
module spi_reg_master_bench;
    localparam int DIV_W    = 8;
    localparam int IDLE_GAP = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_half = 8'd1;
    logic             start = 1'b0;
    logic             wr_en = 1'b0;
    logic [7:0]       reg_id = '0;
    logic [15:0]      sub_idx = '0;
    logic [15:0]      byte_cnt = '0;
    logic [7:0]       wdata;
    logic             wvalid = 1'b0;
    logic             wready, rvalid, busy, done, err, sclk, mosi, miso, cs_n;
    logic [7:0]       rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] wbuf [8];
    logic [7:0] resp [8];
    logic [7:0] cap  [16];
    logic [7:0] rbuf [8];
    int  cap_n, cap_bits, wi, ri, mb;
    logic [7:0] cap_sh;
    logic w_took;
    int  hi_run, last_hi, lead_cnt, tail_cnt;
    logic seen_rise;

    always #2.5 clk = ~clk;

    spi_reg_master #(.DIV_W(DIV_W), .IDLE_GAP(IDLE_GAP)) u_spi_reg_master (
        .clk(clk), .rst_n(rst_n), .div_half(div_half), .start(start),
        .wr_en(wr_en), .reg_id(reg_id), .sub_idx(sub_idx),
        .byte_cnt(byte_cnt), .wdata(wdata), .wvalid(wvalid),
        .wready(wready), .rdata(rdata), .rvalid(rvalid), .busy(busy),
        .done(done), .err(err), .sclk(sclk), .mosi(mosi), .miso(miso),
        .cs_n(cs_n)
    );

    // Slave model: capture MOSI on SCLK rise, shift MISO on SCLK fall.
    always @(posedge sclk) if (!cs_n) begin
        cap_sh = {cap_sh[6:0], mosi};
        cap_bits++;
        if (cap_bits % 8 == 0) begin
            if (cap_n < 16) cap[cap_n] = cap_sh;
            cap_n++;
        end
    end
    always @(negedge cs_n) mb = 0;
    always @(negedge sclk) if (!cs_n) mb++;
    assign miso = resp[(mb >> 3) & 7][7 - (mb & 7)];

    // Write feeder and read collector, sampled away from the active edge.
    assign wdata = wbuf[wi & 7];
    always @(negedge clk) begin
        if (w_took) wi++;
        w_took = wready && wvalid;
        if (rvalid) begin
            if (ri < 8) rbuf[ri] = rdata;
            ri++;
        end
        if (sclk) hi_run++;
        else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
        if (!cs_n && !seen_rise && !sclk) lead_cnt++;
        if (sclk) seen_rise = 1'b1;
        if (sclk) tail_cnt = 0;
        else if (!cs_n) tail_cnt++;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Run one request; optionally re-pulse start after 'bump' cycles.
    task automatic xfer(input logic w, input logic [7:0] id, input logic [15:0] idx,
                        input logic [15:0] len, input int bump, output int gap,
                        output logic got_err);
        int c;
        cap_n = 0; cap_bits = 0; wi = 0; ri = 0; w_took = 1'b0;
        hi_run = 0; last_hi = 0; lead_cnt = 0; tail_cnt = 0; seen_rise = 1'b0;
        wr_en = w; reg_id = id; sub_idx = idx; byte_cnt = len; wvalid = w;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        got_err = err;
        gap = 0;
        if (got_err) return;
        c = 0;
        while (!done && c < 20000) begin
            start = (bump != 0 && c == bump);
            reg_id = (c == bump) ? 8'h01 : id;
            @(negedge clk); c++;
        end
        start = 1'b0; reg_id = id;
        while (busy && gap < 100) begin gap++; @(negedge clk); end
        wvalid = 1'b0;
    endtask

    task automatic t_reset();
        chk(cs_n == 1'b1 && sclk == 1'b0, "R5 reset idle lines", {cs_n, sclk}, 2'b10);
        chk(!busy && !done && !err && !rvalid && !wready, "R6 reset flags",
            {busy, done, err, rvalid, wready}, 0);
    endtask

    task automatic t_one_octet();
        int g; logic e;
        xfer(1'b1, 8'h05, 16'h0000, 16'd0, 0, g, e);
        chk(!e && cap_n == 1, "R9 header-only byte count", cap_n, 1);
        chk(cap[0] == 8'h85, "R1 one-octet write header", cap[0], 8'h85);
        chk(g == IDLE_GAP, "R6 busy gap after done", g, IDLE_GAP);
    endtask

    task automatic t_two_octet_read();
        int g; logic e;
        resp[0] = 8'hE1; resp[1] = 8'hE2; resp[2] = 8'h3C; resp[3] = 8'hA5;
        xfer(1'b0, 8'h11, 16'h0045, 16'd2, 0, g, e);
        chk(cap_n == 4 && cap[0] == 8'h51 && cap[1] == 8'h45, "R2 two-octet header",
            {cap[0], cap[1]}, 16'h5145);
        chk(cap[2] == 8'h00 && cap[3] == 8'h00, "R8 read sends zeros", {cap[2], cap[3]}, 0);
        chk(ri == 2 && rbuf[0] == 8'h3C && rbuf[1] == 8'hA5, "R8 read data after header",
            {rbuf[0], rbuf[1]}, 16'h3CA5);
    endtask

    task automatic t_three_octet_read();
        int g; logic e;
        resp[0] = 8'h11; resp[1] = 8'h22; resp[2] = 8'h33; resp[3] = 8'hDE; resp[4] = 8'h0B;
        xfer(1'b0, 8'h2E, 16'h0806, 16'd2, 0, g, e);
        chk(cap[0] == 8'h6E && cap[1] == 8'h86 && cap[2] == 8'h10, "R3 extended header",
            {cap[0], cap[1], cap[2]}, 24'h6E8610);
        chk(ri == 2 && rbuf[0] == 8'hDE && rbuf[1] == 8'h0B, "R8 data after 3-octet header",
            {rbuf[0], rbuf[1]}, 16'hDE0B);
    endtask

    task automatic t_write();
        int g; logic e;
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        xfer(1'b1, 8'h3F, 16'h0080, 16'd3, 0, g, e);
        chk(cap_n == 6, "R7 write byte count", cap_n, 6);
        chk(cap[0] == 8'hFF && cap[1] == 8'h80 && cap[2] == 8'h01, "R3 header at 0x80",
            {cap[0], cap[1], cap[2]}, 24'hFF8001);
        chk(cap[3] == 8'hA1 && cap[4] == 8'hB2 && cap[5] == 8'hC3, "R7 payload order",
            {cap[3], cap[4], cap[5]}, 24'hA1B2C3);
    endtask

    task automatic t_reject();
        int g; logic e; int fell;
        logic [7:0] ids [3] = '{8'h40, 8'h01, 8'h01};
        logic [15:0] ix [3] = '{16'h0000, 16'h8000, 16'h7FF0};
        logic [15:0] ln [3] = '{16'd0, 16'd0, 16'h0020};
        for (int k = 0; k < 3; k++) begin
            xfer(1'b0, ids[k], ix[k], ln[k], 0, g, e);
            chk(e == 1'b1, "R4 err strobe after start", e, 1);
            @(negedge clk);
            chk(err == 1'b0, "R4 err one cycle", err, 0);
            fell = 0;
            for (int c = 0; c < 20; c++) begin
                if (!cs_n || busy) fell = 1;
                @(negedge clk);
            end
            chk(fell == 0 && cap_n == 0, "R4 no bus activity", fell, 0);
        end
        resp[3] = 8'h77;
        xfer(1'b0, 8'h02, 16'h7FFE, 16'd1, 0, g, e);
        chk(!e && cap[1] == 8'hFE && cap[2] == 8'hFF && rbuf[0] == 8'h77,
            "R4 boundary span accepted", {cap[1], cap[2]}, 16'hFEFF);
    endtask

    task automatic t_timing();
        int g; logic e;
        div_half = 8'd3;
        xfer(1'b1, 8'h07, 16'h0003, 16'd0, 0, g, e);
        chk(last_hi == 4, "R5 SCLK high time", last_hi, 4);
        chk(lead_cnt >= 4, "R6 chip-select lead", lead_cnt, 4);
        chk(tail_cnt >= 4, "R6 chip-select tail", tail_cnt, 4);
        chk(cap[0] == 8'hC7 && cap[1] == 8'h03, "R2 header at slow rate",
            {cap[0], cap[1]}, 16'hC703);
        div_half = 8'd1;
    endtask

    task automatic t_busy_start();
        int g; logic e;
        xfer(1'b1, 8'h0A, 16'h0000, 16'd0, 5, g, e);
        repeat (30) @(negedge clk);
        chk(cap_n == 1 && cap[0] == 8'h8A, "R10 start while busy ignored", cap_n, 1);
    endtask

    initial begin
        fork
            begin
                for (int k = 0; k < 8; k++) begin resp[k] = 8'h00; wbuf[k] = 8'h00; end
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_one_octet();
                t_two_octet_read();
                t_three_octet_read();
                t_write();
                t_reject();
                t_timing();
                t_busy_start();
            end
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule